// File: doc/BRIEF.md
# Dual-Mode Sliced Shift-Register Bank

This block holds the sixteen-cell shift register shared by two word-oriented stream ciphers. One cipher uses 32-bit cells and the other uses 31-bit cells. Each cell is stored as two independent 16-bit halves, so the bank is a set of thirty-two separate 16-bit registers. Any pipeline stage can read each register directly through the half outputs. A single mode input chooses how a word is split into halves on a write and how it is rebuilt on a read.

In 31-bit mode the middle bit of a word, bit 15, is kept in both halves. The upper half therefore holds bits 30..15 and the lower half holds bits 15..0. With this layout the four 32-bit bit-reorganisation words can be taken straight from half boundaries. The bank drives them as parallel outputs, so the nonlinear stage that uses them does not have to build them. The feedback arithmetic, the nonlinear stage and the lookup tables are outside this block.

The bank is moved in two pipeline steps. A shift strobe moves cells 1..15 down by one position. A separate feedback strobe writes the newly computed top cell. When both strobes fall in the same cycle, cell 14 takes the old top cell and the top cell takes the feedback word. A parallel load fills every cell in one cycle and takes priority over both strobes.

Top module: `dual_lfsr_bank`

## Requirements
- R1: With `mode_31`=0, cell k is written from a 32-bit word w as upper half w[31:16] and lower half w[15:0]. Cell k reads back on `cell_words[32k+31:32k]` as w, unchanged.
- R2: With `mode_31`=1, a 32-bit word w is written as upper half w[30:15] and lower half w[15:0]. Bit 31 of w has no effect on either half.
- R3: With `mode_31`=1, cell k reads back as {1'b0, upper[15:0], lower[14:0]}. After any write in this mode, bit 0 of the upper half equals bit 15 of the lower half.
- R4: When `load_en` is high, all 16 cells take their words from `load_words` (cell k at bits 32k+31..32k) at the next clock edge, packed by the current mode. This holds even when `shift_en` or `fb_we` is high in the same cycle.
- R5: When `shift_en` is high and `load_en` is low, cell k takes the old contents of cell k+1 for k = 0..14 at the next edge. Without `fb_we`, cell 15 keeps its value.
- R6: When `fb_we` is high and `load_en` is low, cell 15 takes `fb_word`, packed by the current mode. If `shift_en` is also high, cell 14 receives the old cell 15 in the same edge.
- R7: With `load_en`, `shift_en` and `fb_we` all low, all 32 halves keep their values.
- R8: With `mode_31`=1, and writing H(k) and L(k) for the upper and lower halves of cell k:
  - `x0` = {H(15), L(14)}
  - `x1` = {L(11), H(9)}
  - `x2` = {L(7), H(5)}
  - `x3` = {L(2), H(0)}
- R9: With `mode_31`=0, `x0`..`x3` are all zero.
- R10: While `rst_n` is low, and for the cycles until its synchronised release, all halves are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| mode_31 | input | 1 | 1 selects 31-bit cell packing, 0 selects 32-bit packing |
| load_en | input | 1 | Parallel load of all cells |
| load_words | input | 512 | Sixteen load words, cell k at bits 32k+31..32k |
| shift_en | input | 1 | Move cells 1..15 down by one position |
| fb_we | input | 1 | Write the feedback word into cell 15 |
| fb_word | input | 32 | Feedback word for cell 15 |
| half_hi | output | 256 | Upper halves, cell k at bits 16k+15..16k |
| half_lo | output | 256 | Lower halves, cell k at bits 16k+15..16k |
| cell_words | output | 512 | Rebuilt cell words, cell k at bits 32k+31..32k |
| x0 | output | 32 | Bit-reorganisation word 0 |
| x1 | output | 32 | Bit-reorganisation word 1 |
| x2 | output | 32 | Bit-reorganisation word 2 |
| x3 | output | 32 | Bit-reorganisation word 3 |

## Verification
In 31-bit mode the bench loads words with bit 31 set and with bit 15 differing from its neighbours. A design that did not duplicate the middle bit, or that let bit 31 reach a half, would then show wrong halves, wrong rebuilt words and wrong X words. The bench asserts shift and feedback in the same cycle: a design that wrote cell 14 from the new top cell would drop a word from the sequence. It also asserts load together with both strobes, which catches a design that ranks the strobes above the load. Finally it checks that the X words read zero in 32-bit mode and keep their exact half order in 31-bit mode, since swapped halves or swapped taps corrupt the word handed to the nonlinear stage.

// File: rtl/lfsr_bank_pkg.sv
package lfsr_bank_pkg;

  typedef enum logic {
    PACK_W32 = 1'b0,
    PACK_W31 = 1'b1
  } pack_mode_e;

  // cell indices feeding the bit-reorganisation words (upper/lower half picks)
  localparam int TAP_X0_HI = 15;
  localparam int TAP_X0_LO = 14;
  localparam int TAP_X1_LO = 11;
  localparam int TAP_X1_HI = 9;
  localparam int TAP_X2_LO = 7;
  localparam int TAP_X2_HI = 5;
  localparam int TAP_X3_LO = 2;
  localparam int TAP_X3_HI = 0;
  localparam int MIN_CELLS = 16;

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_core_n = sync_q;
endmodule

// File: rtl/lfsr_word_pack.sv
module lfsr_word_pack #(
  parameter int HALF_W = 16
) (
  input  logic                  mode_31,
  input  logic [2*HALF_W-1:0]   word,
  output logic [HALF_W-1:0]     hi,
  output logic [HALF_W-1:0]     lo
);
  import lfsr_bank_pkg::*;
  localparam int WORD_W = 2 * HALF_W;

  always_comb begin
    lo = word[HALF_W-1:0];
    if (pack_mode_e'(mode_31) == PACK_W31) begin
      // middle bit lands in both halves
      hi = word[WORD_W-2:HALF_W-1];
    end else begin
      hi = word[WORD_W-1:HALF_W];
    end
  end
endmodule

// File: rtl/lfsr_word_unpack.sv
module lfsr_word_unpack #(
  parameter int HALF_W = 16
) (
  input  logic                  mode_31,
  input  logic [HALF_W-1:0]     hi,
  input  logic [HALF_W-1:0]     lo,
  output logic [2*HALF_W-1:0]   word
);
  import lfsr_bank_pkg::*;

  always_comb begin
    if (pack_mode_e'(mode_31) == PACK_W31) begin
      word = {1'b0, hi, lo[HALF_W-2:0]};
    end else begin
      word = {hi, lo};
    end
  end
endmodule

// File: rtl/lfsr_slot.sv
module lfsr_slot #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_core_n,
  input  logic              slot_en,
  input  logic [HALF_W-1:0] d_hi,
  input  logic [HALF_W-1:0] d_lo,
  output logic [HALF_W-1:0] q_hi,
  output logic [HALF_W-1:0] q_lo
);
  logic [HALF_W-1:0] hi_q, lo_q;
  logic [HALF_W-1:0] hi_nxt, lo_nxt;

  always_comb begin
    hi_nxt = hi_q;
    lo_nxt = lo_q;
    if (slot_en) begin
      hi_nxt = d_hi;
      lo_nxt = d_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      hi_q <= hi_nxt;
      lo_q <= lo_nxt;
    end
  end

  assign q_hi = hi_q;
  assign q_lo = lo_q;
endmodule

// File: rtl/lfsr_xword_tap.sv
module lfsr_xword_tap #(
  parameter int HALF_W = 16,
  parameter int CELLS  = 16
) (
  input  logic                       mode_31,
  input  logic [CELLS*HALF_W-1:0]    half_hi,
  input  logic [CELLS*HALF_W-1:0]    half_lo,
  output logic [2*HALF_W-1:0]        x0,
  output logic [2*HALF_W-1:0]        x1,
  output logic [2*HALF_W-1:0]        x2,
  output logic [2*HALF_W-1:0]        x3
);
  import lfsr_bank_pkg::*;

  logic [HALF_W-1:0] h15, l14, l11, h9, l7, h5, l2, h0;

  assign h15 = half_hi[TAP_X0_HI*HALF_W +: HALF_W];
  assign l14 = half_lo[TAP_X0_LO*HALF_W +: HALF_W];
  assign l11 = half_lo[TAP_X1_LO*HALF_W +: HALF_W];
  assign h9  = half_hi[TAP_X1_HI*HALF_W +: HALF_W];
  assign l7  = half_lo[TAP_X2_LO*HALF_W +: HALF_W];
  assign h5  = half_hi[TAP_X2_HI*HALF_W +: HALF_W];
  assign l2  = half_lo[TAP_X3_LO*HALF_W +: HALF_W];
  assign h0  = half_hi[TAP_X3_HI*HALF_W +: HALF_W];

  always_comb begin
    x0 = '0;
    x1 = '0;
    x2 = '0;
    x3 = '0;
    if (pack_mode_e'(mode_31) == PACK_W31) begin
      x0 = {h15, l14};
      x1 = {l11, h9};
      x2 = {l7, h5};
      x3 = {l2, h0};
    end
  end
endmodule

// File: rtl/dual_lfsr_bank.sv
module dual_lfsr_bank #(
  parameter int HALF_W = 16,
  parameter int CELLS  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_31,
  input  logic                          load_en,
  input  logic [CELLS*2*HALF_W-1:0]     load_words,
  input  logic                          shift_en,
  input  logic                          fb_we,
  input  logic [2*HALF_W-1:0]           fb_word,
  output logic [CELLS*HALF_W-1:0]       half_hi,
  output logic [CELLS*HALF_W-1:0]       half_lo,
  output logic [CELLS*2*HALF_W-1:0]     cell_words,
  output logic [2*HALF_W-1:0]           x0,
  output logic [2*HALF_W-1:0]           x1,
  output logic [2*HALF_W-1:0]           x2,
  output logic [2*HALF_W-1:0]           x3
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int TOP    = CELLS - 1;

  logic rst_core_n;

  lfsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  logic [HALF_W-1:0] fb_hi, fb_lo;

  lfsr_word_pack #(.HALF_W(HALF_W)) u_fb_pack (
    .mode_31 (mode_31),
    .word    (fb_word),
    .hi      (fb_hi),
    .lo      (fb_lo)
  );

  logic [HALF_W-1:0] q_hi [CELLS];
  logic [HALF_W-1:0] q_lo [CELLS];

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic [HALF_W-1:0] ld_hi, ld_lo;
    logic [HALF_W-1:0] src_hi, src_lo;
    logic [HALF_W-1:0] d_hi, d_lo;
    logic              move_en;
    logic              slot_en;

    lfsr_word_pack #(.HALF_W(HALF_W)) u_ld_pack (
      .mode_31 (mode_31),
      .word    (load_words[i*WORD_W +: WORD_W]),
      .hi      (ld_hi),
      .lo      (ld_lo)
    );

    if (i == TOP) begin : g_top
      // second movement step: feedback write
      assign src_hi  = fb_hi;
      assign src_lo  = fb_lo;
      assign move_en = fb_we;
    end else begin : g_body
      // first movement step: shift from the neighbour above
      assign src_hi  = q_hi[i+1];
      assign src_lo  = q_lo[i+1];
      assign move_en = shift_en;
    end

    always_comb begin
      d_hi = src_hi;
      d_lo = src_lo;
      if (load_en) begin
        d_hi = ld_hi;
        d_lo = ld_lo;
      end
    end

    assign slot_en = load_en | move_en;

    lfsr_slot #(.HALF_W(HALF_W)) u_slot (
      .clk        (clk),
      .rst_core_n (rst_core_n),
      .slot_en    (slot_en),
      .d_hi       (d_hi),
      .d_lo       (d_lo),
      .q_hi       (q_hi[i]),
      .q_lo       (q_lo[i])
    );

    assign half_hi[i*HALF_W +: HALF_W] = q_hi[i];
    assign half_lo[i*HALF_W +: HALF_W] = q_lo[i];

    lfsr_word_unpack #(.HALF_W(HALF_W)) u_unpack (
      .mode_31 (mode_31),
      .hi      (q_hi[i]),
      .lo      (q_lo[i]),
      .word    (cell_words[i*WORD_W +: WORD_W])
    );
  end

  lfsr_xword_tap #(.HALF_W(HALF_W), .CELLS(CELLS)) u_xtap (
    .mode_31 (mode_31),
    .half_hi (half_hi),
    .half_lo (half_lo),
    .x0      (x0),
    .x1      (x1),
    .x2      (x2),
    .x3      (x3)
  );
endmodule

// File: rtl/dual_lfsr_bank_chk.sv
module dual_lfsr_bank_chk #(
  parameter int HALF_W = 16,
  parameter int CELLS  = 16
) (
  input logic                          clk,
  input logic                          rst_core_n,
  input logic                          mode_31,
  input logic                          load_en,
  input logic [CELLS*2*HALF_W-1:0]     load_words,
  input logic                          shift_en,
  input logic                          fb_we,
  input logic [2*HALF_W-1:0]           fb_word,
  input logic [CELLS*HALF_W-1:0]       half_hi,
  input logic [CELLS*HALF_W-1:0]       half_lo,
  input logic [CELLS*2*HALF_W-1:0]     cell_words
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int TOP    = CELLS - 1;

  function automatic logic [CELLS*WORD_W-1:0] low31_mask();
    logic [CELLS*WORD_W-1:0] m;
    for (int k = 0; k < CELLS; k++) begin
      m[k*WORD_W +: WORD_W] = {1'b0, {(WORD_W-1){1'b1}}};
    end
    return m;
  endfunction

  localparam logic [CELLS*WORD_W-1:0] MASK31 = low31_mask();

  logic dup_ok;
  always_comb begin
    dup_ok = 1'b1;
    for (int k = 0; k < CELLS; k++) begin
      if (half_hi[k*HALF_W] != half_lo[k*HALF_W + HALF_W - 1]) dup_ok = 1'b0;
    end
  end

  a_r4_load32: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && !mode_31) |=> (mode_31 || cell_words == $past(load_words)));

  a_r4_load31: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && mode_31) |=> (!mode_31 || (cell_words & MASK31) == ($past(load_words) & MASK31)));

  a_r3_middle_dup: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load_en && mode_31) |=> dup_ok);

  a_r5_shift_down: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_en && shift_en) |=>
      (half_hi[0 +: HALF_W] == $past(half_hi[HALF_W +: HALF_W]) &&
       half_lo[0 +: HALF_W] == $past(half_lo[HALF_W +: HALF_W]) &&
       half_hi[(TOP-1)*HALF_W +: HALF_W] == $past(half_hi[TOP*HALF_W +: HALF_W])));

  a_r6_fb_write32: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_en && fb_we && !mode_31) |=>
      (mode_31 || cell_words[TOP*WORD_W +: WORD_W] == $past(fb_word)));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!load_en && !shift_en && !fb_we) |=> ($stable(half_hi) && $stable(half_lo)));
endmodule

bind dual_lfsr_bank dual_lfsr_bank_chk #(.HALF_W(HALF_W), .CELLS(CELLS)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .mode_31    (mode_31),
  .load_en    (load_en),
  .load_words (load_words),
  .shift_en   (shift_en),
  .fb_we      (fb_we),
  .fb_word    (fb_word),
  .half_hi    (half_hi),
  .half_lo    (half_lo),
  .cell_words (cell_words)
);

// File: tb/dual_lfsr_bank_bench.sv
module dual_lfsr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H = 16;
  localparam int N = 16;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic mode_31;
  logic load_en;
  logic [N*W-1:0] load_words;
  logic shift_en;
  logic fb_we;
  logic [W-1:0] fb_word;
  logic [N*H-1:0] half_hi, half_lo;
  logic [N*W-1:0] cell_words;
  logic [W-1:0] x0, x1, x2, x3;

  int checks = 0;
  int errors = 0;

  logic [H-1:0] m_hi [N];
  logic [H-1:0] m_lo [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_lfsr_bank u_dual_lfsr_bank (
    .clk(clk), .rst_n(rst_n), .mode_31(mode_31), .load_en(load_en),
    .load_words(load_words), .shift_en(shift_en), .fb_we(fb_we),
    .fb_word(fb_word), .half_hi(half_hi), .half_lo(half_lo),
    .cell_words(cell_words), .x0(x0), .x1(x1), .x2(x2), .x3(x3)
  );

  // packing per R1/R2
  function automatic logic [2*H-1:0] ref_pack(input logic [W-1:0] w, input logic m);
    if (m) return {w[30:15], w[15:0]};
    return {w[31:16], w[15:0]};
  endfunction

  // rebuild per R1/R3
  function automatic logic [W-1:0] ref_word(input int k, input logic m);
    if (m) return {1'b0, m_hi[k], m_lo[k][14:0]};
    return {m_hi[k], m_lo[k]};
  endfunction

  task automatic compare(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_bank(input string req);
    for (int k = 0; k < N; k++) begin
      compare(req, $sformatf("halves[%0d]", k),
              {half_hi[k*H +: H], half_lo[k*H +: H]}, {m_hi[k], m_lo[k]});
      compare(req, $sformatf("cell[%0d]", k), cell_words[k*W +: W], ref_word(k, mode_31));
    end
  endtask

  // R8 and R9 expected X words
  task automatic check_x(input string req);
    if (mode_31) begin
      compare(req, "x0", x0, {m_hi[15], m_lo[14]});
      compare(req, "x1", x1, {m_lo[11], m_hi[9]});
      compare(req, "x2", x2, {m_lo[7], m_hi[5]});
      compare(req, "x3", x3, {m_lo[2], m_hi[0]});
    end else begin
      compare(req, "x0", x0, '0);
      compare(req, "x1", x1, '0);
      compare(req, "x2", x2, '0);
      compare(req, "x3", x3, '0);
    end
  endtask

  task automatic step(input logic ld, input logic [N*W-1:0] words,
                      input logic sh, input logic fb, input logic [W-1:0] fbw);
    logic [H-1:0] nh [N];
    logic [H-1:0] nl [N];
    @(negedge clk);
    load_en = ld; load_words = words; shift_en = sh; fb_we = fb; fb_word = fbw;
    @(posedge clk);
    for (int k = 0; k < N; k++) begin nh[k] = m_hi[k]; nl[k] = m_lo[k]; end
    if (ld) begin
      for (int k = 0; k < N; k++) {nh[k], nl[k]} = ref_pack(words[k*W +: W], mode_31);
    end else begin
      if (sh) for (int k = 0; k < N-1; k++) begin nh[k] = m_hi[k+1]; nl[k] = m_lo[k+1]; end
      if (fb) {nh[N-1], nl[N-1]} = ref_pack(fbw, mode_31);
    end
    for (int k = 0; k < N; k++) begin m_hi[k] = nh[k]; m_lo[k] = nl[k]; end
    #1;
    load_en = 1'b0; shift_en = 1'b0; fb_we = 1'b0;
  endtask

  function automatic logic [N*W-1:0] pattern(input logic [W-1:0] seed);
    logic [N*W-1:0] p;
    logic [W-1:0] v = seed;
    for (int k = 0; k < N; k++) begin
      v = {v[30:0], v[31] ^ v[21] ^ v[1] ^ v[0]} ^ (32'h9E37_79B9 * (k + 1));
      p[k*W +: W] = v;
    end
    return p;
  endfunction

  task automatic t_reset();
    for (int k = 0; k < N; k++) begin m_hi[k] = '0; m_lo[k] = '0; end
    check_bank("R10");
  endtask

  task automatic t_load32();
    mode_31 = 1'b0;
    step(1'b1, pattern(32'hC0DE_0001), 1'b0, 1'b0, '0);
    check_bank("R1");
    check_x("R9");
  endtask

  task automatic t_load31();
    logic [N*W-1:0] p = pattern(32'h1357_2468);
    mode_31 = 1'b1;
    for (int k = 0; k < N; k++) begin
      p[k*W + 31] = 1'b1;           // bit 31 must not matter (R2)
      p[k*W + 15] = k[0];           // middle bit varies
    end
    step(1'b1, p, 1'b0, 1'b0, '0);
    check_bank("R2");
    for (int k = 0; k < N; k++)
      compare("R3", $sformatf("dup[%0d]", k), {31'd0, half_hi[k*H]}, {31'd0, half_lo[k*H + H - 1]});
    check_x("R8");
  endtask

  task automatic t_shift_fb31();
    mode_31 = 1'b1;
    step(1'b0, '0, 1'b1, 1'b0, '0);
    check_bank("R5");
    check_x("R8");
    for (int j = 0; j < 5; j++) begin
      step(1'b0, '0, 1'b1, 1'b1, 32'hF00D_8000 ^ (j * 32'h0123_4567));
      check_bank("R6");
      check_x("R8");
    end
    step(1'b0, '0, 1'b0, 1'b1, 32'h7FFF_0000);
    check_bank("R6");
  endtask

  task automatic t_fb32();
    mode_31 = 1'b0;
    step(1'b0, '0, 1'b1, 1'b1, 32'hDEAD_BEEF);
    check_bank("R6");
    check_x("R9");
  endtask

  task automatic t_priority();
    mode_31 = 1'b0;
    step(1'b1, pattern(32'hAAAA_5555), 1'b1, 1'b1, 32'h1234_5678);
    check_bank("R4");
    mode_31 = 1'b1;
    step(1'b1, pattern(32'h0F0F_F0F0), 1'b1, 1'b1, 32'h8765_4321);
    check_bank("R4");
  endtask

  task automatic t_hold();
    for (int j = 0; j < 3; j++) step(1'b0, '1, 1'b0, 1'b0, '1);
    check_bank("R7");
    check_x("R8");
  endtask

  initial begin
    rst_n = 1'b0; mode_31 = 1'b0; load_en = 1'b0; load_words = '0;
    shift_en = 1'b0; fb_we = 1'b0; fb_word = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load32();
    t_load31();
    t_shift_fb31();
    t_fb32();
    t_priority();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule